// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block recovers packets from a low-speed USB bus whose D+ and D- pins are
sampled by a clock running at eight times the bit rate. It passes both pins
through a synchroniser and waits for D- to read high, which means either an idle
bus or a detached one. It then hunts for the sync pattern, using each edge on D-
to re-centre its sampling point. Once two K bits arrive back to back it is
locked. From then on it decodes NRZI, drops stuffed bits and packs the data bits
into bytes, least significant bit first.

Each completed byte is delivered with a one-cycle strobe. A single-ended-zero
condition closes the packet, and the block then reports how many whole bytes
arrived, counting the PID byte. If a packet carries more bytes than the
configured buffer depth, the receiver drops it and raises an overflow pulse. The
consumer writes the bytes into its own buffer and acts on the done or overflow
pulse. CRC checking and token decoding happen further downstream.

Top module: `usb_ls_rx`

## Requirements
- R1: During reset and in the first cycle after it, `byte_valid_o`, `pkt_done_o` and `overflow_o` are low.
- R2: A line state is {dp,dm}: 01 is J (idle), 10 is K, 00 is SE0. After reset and after every packet end or abort, the receiver ignores the bus until D- reads high. K bits seen while D- has been low since the end of the last packet never lead to lock.
- R3: Lock needs two consecutive K samples while hunting. A lone K followed by a J clears the hunt, and sampling SE0 or SE1 while hunting returns to waiting for D- high.
- R4: The sampling phase is restarted by every transition of the synchronised D-. The line is sampled OVERSAMPLE/2 clocks after such a transition and every OVERSAMPLE clocks after that. Bit widths alternating between OVERSAMPLE-1 and OVERSAMPLE+1 clocks are received correctly.
- R5: The NRZI decoder reads a data bit as 1 when the sampled D- level equals the previous one and as 0 when it differs. The reference level at lock is K.
- R6: After six consecutive decoded 1 bits the next bit is discarded. The final 1 of the sync pattern counts as the first of such a run.
- R7: Data bits are packed LSB first. Each completed byte appears on `byte_o` together with a one-cycle `byte_valid_o` pulse.
- R8: SE0 sampled at bit positions 1 to 7 of a byte ends the packet and discards the partial byte. At bit position 0, SE0 is decoded by its D- level (as K), so one dribble bit before the end of packet is harmless.
- R9: At the end of a packet, `pkt_done_o` pulses for one cycle. `pkt_bytes_o` then holds the count of whole bytes received, including the PID, and may be 0.
- R10: When byte number BUF_BYTES+1 completes, that byte is not delivered. `overflow_o` pulses, no `pkt_done_o` follows, and the receiver waits for D- high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, OVERSAMPLE times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| dp_i | input | 1 | Raw D+ pin level |
| dm_i | input | 1 | Raw D- pin level |
| byte_valid_o | output | 1 | One-cycle strobe for a completed byte |
| byte_o | output | 8 | Received byte, valid with the strobe |
| pkt_done_o | output | 1 | One-cycle pulse at the end of a packet |
| pkt_bytes_o | output | $clog2(BUF_BYTES+1) | Byte count of the last completed packet |
| overflow_o | output | 1 | One-cycle pulse when a packet exceeds BUF_BYTES |

## Verification
The bench builds the block with OVERSAMPLE = 8 and BUF_BYTES = 4. The small depth lets a five-byte packet trigger overflow. It also means that sixty-four full four-byte packets carry every byte value 0 to 255 through the decoder, once with nominal bit widths and once with widths alternating between 7 and 9 clocks. Further packets cover heavy stuffing (all-ones payloads of every length up to the depth), an empty packet, a dribble bit, a false sync start and K bits sent while the bus is still in SE0.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

    // bit 1 = D+, bit 0 = D-
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_HUNT = 2'd1,
        ST_DATA = 2'd2
    } rx_state_e;

    localparam int STUFF_RUN = 6;

    // NRZI: unchanged level is a one
    function automatic logic nrzi_bit(input logic level, input logic prev_level);
        return level == prev_level;
    endfunction

endpackage

// File: rtl/usb_ls_line_sync.sv
module usb_ls_line_sync
    import usb_ls_rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  dp_i,
    input  logic  dm_i,
    output line_e line_o,
    output logic  dm_edge_o
);
    logic [STAGES-1:0] dp_pipe;
    logic [STAGES-1:0] dm_pipe;
    logic              dm_last;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    dp_pipe <= '0;
                    dm_pipe <= '0;
                end else begin
                    dp_pipe <= dp_i;
                    dm_pipe <= dm_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    dp_pipe <= '0;
                    dm_pipe <= '0;
                end else begin
                    dp_pipe <= {dp_pipe[STAGES-2:0], dp_i};
                    dm_pipe <= {dm_pipe[STAGES-2:0], dm_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) dm_last <= 1'b0;
        else     dm_last <= dm_pipe[STAGES-1];
    end

    assign line_o    = line_e'({dp_pipe[STAGES-1], dm_pipe[STAGES-1]});
    assign dm_edge_o = dm_pipe[STAGES-1] ^ dm_last;

endmodule

// File: rtl/usb_ls_bit_timer.sv
module usb_ls_bit_timer #(
    parameter int OVERSAMPLE = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic resync_i,
    output logic strobe_o
);
    localparam int PH_W = $clog2(OVERSAMPLE);
    localparam logic [PH_W-1:0] CENTER = PH_W'(OVERSAMPLE / 2);
    localparam logic [PH_W-1:0] LAST   = PH_W'(OVERSAMPLE - 1);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)                phase_q <= '0;
        else if (resync_i)      phase_q <= PH_W'(1);
        else if (phase_q == LAST) phase_q <= '0;
        else                    phase_q <= phase_q + PH_W'(1);
    end

    assign strobe_o = (phase_q == CENTER) && !resync_i;

endmodule

// File: rtl/usb_ls_destuff_shift.sv
module usb_ls_destuff_shift
    import usb_ls_rx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_i,
    input  logic              bit_en_i,
    input  logic              bit_i,
    output logic              byte_done_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              first_bit_o
);
    localparam int POS_W  = $clog2(BYTE_W);
    localparam int ONES_W = $clog2(STUFF_RUN + 1);
    localparam logic [POS_W-1:0]  LAST_POS = POS_W'(BYTE_W - 1);
    localparam logic [ONES_W-1:0] RUN_MAX  = ONES_W'(STUFF_RUN);

    logic [BYTE_W-1:0] sh_q;
    logic [POS_W-1:0]  pos_q;
    logic [ONES_W-1:0] ones_q;
    logic              stuffed;
    logic              take;

    assign stuffed     = ones_q == RUN_MAX;
    assign take        = bit_en_i && !stuffed;
    assign byte_o      = {bit_i, sh_q[BYTE_W-1:1]};
    assign byte_done_o = take && (pos_q == LAST_POS);
    assign first_bit_o = pos_q == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            pos_q  <= '0;
            ones_q <= '0;
        end else if (init_i) begin
            sh_q   <= '0;
            pos_q  <= '0;
            ones_q <= ONES_W'(1);   // last sync bit is a one
        end else if (bit_en_i) begin
            if (stuffed) begin
                ones_q <= '0;
            end else begin
                ones_q <= bit_i ? ones_q + ONES_W'(1) : '0;
                sh_q   <= byte_o;
                pos_q  <= (pos_q == LAST_POS) ? '0 : pos_q + POS_W'(1);
            end
        end
    end

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
    import usb_ls_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 8,
    parameter int BUF_BYTES   = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dp_i,
    input  logic             dm_i,
    output logic             byte_valid_o,
    output logic [7:0]       byte_o,
    output logic             pkt_done_o,
    output logic [CNT_W-1:0] pkt_bytes_o,
    output logic             overflow_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BUF_BYTES);

    line_e      line;
    logic       lvl;
    logic       dm_edge;
    logic       strobe;
    rx_state_e  state_q, state_d;
    logic       saw_k_q, saw_k_d;
    logic       prev_q, prev_d;
    logic [CNT_W-1:0] count_q;
    logic       init;
    logic       bit_en;
    logic       bit_val;
    logic       end_pkt;
    logic       byte_done;
    logic [7:0] byte_data;
    logic       first_bit;
    logic       full;
    logic       ovf_now;

    usb_ls_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .dp_i     (dp_i),
        .dm_i     (dm_i),
        .line_o   (line),
        .dm_edge_o(dm_edge)
    );

    usb_ls_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .resync_i(dm_edge),
        .strobe_o(strobe)
    );

    usb_ls_destuff_shift #(.BYTE_W(8)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .init_i     (init),
        .bit_en_i   (bit_en),
        .bit_i      (bit_val),
        .byte_done_o(byte_done),
        .byte_o     (byte_data),
        .first_bit_o(first_bit)
    );

    assign lvl     = line[0];
    assign bit_val = nrzi_bit(lvl, prev_q);
    assign full    = count_q == FULL;
    assign ovf_now = byte_done && full;

    always_comb begin
        state_d = state_q;
        saw_k_d = saw_k_q;
        prev_d  = prev_q;
        init    = 1'b0;
        bit_en  = 1'b0;
        end_pkt = 1'b0;
        case (state_q)
            ST_WAIT: begin
                if (lvl) begin
                    state_d = ST_HUNT;
                    saw_k_d = 1'b0;
                end
            end
            ST_HUNT: begin
                if (strobe) begin
                    case (line)
                        LN_K: begin
                            if (saw_k_q) begin
                                state_d = ST_DATA;
                                init    = 1'b1;
                                prev_d  = 1'b0;
                            end else begin
                                saw_k_d = 1'b1;
                            end
                        end
                        LN_J:    saw_k_d = 1'b0;
                        default: state_d = ST_WAIT;
                    endcase
                end
            end
            ST_DATA: begin
                if (strobe) begin
                    if (line == LN_SE0 && !first_bit) begin
                        end_pkt = 1'b1;
                        state_d = ST_WAIT;
                    end else begin
                        bit_en = 1'b1;
                        prev_d = lvl;
                    end
                end
            end
            default: state_d = ST_WAIT;
        endcase
        if (ovf_now) state_d = ST_WAIT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_WAIT;
            saw_k_q      <= 1'b0;
            prev_q       <= 1'b0;
            count_q      <= '0;
            byte_valid_o <= 1'b0;
            byte_o       <= '0;
            pkt_done_o   <= 1'b0;
            pkt_bytes_o  <= '0;
            overflow_o   <= 1'b0;
        end else begin
            state_q      <= state_d;
            saw_k_q      <= saw_k_d;
            prev_q       <= prev_d;
            byte_valid_o <= byte_done && !full;
            pkt_done_o   <= end_pkt;
            overflow_o   <= ovf_now;
            if (byte_done)  byte_o <= byte_data;
            if (end_pkt)    pkt_bytes_o <= count_q;
            if (init)                       count_q <= '0;
            else if (byte_done && !full)    count_q <= count_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/usb_ls_rx_checker.sv
module usb_ls_rx_checker
    import usb_ls_rx_pkg::*;
#(
    parameter int BUF_BYTES = 8,
    parameter int CNT_W     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             byte_valid_o,
    input logic             pkt_done_o,
    input logic [CNT_W-1:0] pkt_bytes_o,
    input logic             overflow_o,
    input rx_state_e        state_q,
    input logic             dm_sync
);
    // R9: the three strobes never coincide
    p_strobes_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({byte_valid_o, pkt_done_o, overflow_o}));

    // R7: bytes are at least a bit time apart
    p_byte_single_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |=> !byte_valid_o);

    // R9: reported count fits the buffer
    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        pkt_done_o |-> (pkt_bytes_o <= CNT_W'(BUF_BYTES)));

    // R8: a packet end comes only out of data reception
    p_done_from_data_r8: assert property (@(posedge clk) disable iff (rst)
        pkt_done_o |-> ($past(state_q) == ST_DATA));

    // R10: overflow leaves the receiver waiting for idle
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        overflow_o |-> (state_q != ST_DATA));

    // R2: no lock straight out of the wait state while D- is low
    p_wait_no_lock_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !dm_sync) |=> (state_q == ST_WAIT));

    // R10: overflow is a single pulse
    p_overflow_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> !overflow_o);

endmodule

bind usb_ls_rx usb_ls_rx_checker #(
    .BUF_BYTES(BUF_BYTES),
    .CNT_W    (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .byte_valid_o(byte_valid_o),
    .pkt_done_o  (pkt_done_o),
    .pkt_bytes_o (pkt_bytes_o),
    .overflow_o  (overflow_o),
    .state_q     (state_q),
    .dm_sync     (lvl)
);

// File: tb/usb_ls_rx_tb.sv
`timescale 1ns/1ps
module usb_ls_rx_tb;
    localparam int OS  = 8;
    localparam int BUF = 4;
    localparam int CW  = $clog2(BUF + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dp  = 1'b0;
    logic          dm  = 1'b1;
    logic          byte_valid;
    logic [7:0]    byte_out;
    logic          pkt_done;
    logic [CW-1:0] pkt_bytes;
    logic          overflow;

    always #2 clk = ~clk;

    usb_ls_rx #(.OVERSAMPLE(OS), .BUF_BYTES(BUF)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .dp_i        (dp),
        .dm_i        (dm),
        .byte_valid_o(byte_valid),
        .byte_o      (byte_out),
        .pkt_done_o  (pkt_done),
        .pkt_bytes_o (pkt_bytes),
        .overflow_o  (overflow)
    );

    int         n_chk = 0;
    int         n_bad = 0;
    bit         finished = 1'b0;
    logic [7:0] got_q[$];
    int         done_n = 0;
    int         ovf_n = 0;
    int         last_cnt = 0;
    logic [7:0] pkt [0:7];
    logic       tx_lvl;
    int         ones;
    int         bit_idx = 0;
    bit         jitter = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid) got_q.push_back(byte_out);
            if (pkt_done) begin
                done_n++;
                last_cnt = int'(pkt_bytes);
            end
            if (overflow) ovf_n++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put(input logic dpv, input logic dmv, input int dur);
        dp = dpv;
        dm = dmv;
        repeat (dur) @(negedge clk);
    endtask

    task automatic tx_bit(input logic b);
        int dur;
        if (!b) tx_lvl = ~tx_lvl;
        if (jitter) begin
            bit_idx++;
            dur = (bit_idx % 2 == 1) ? OS + 1 : OS - 1;
        end else begin
            dur = OS;
        end
        put(~tx_lvl, tx_lvl, dur);
    endtask

    task automatic tx_data(input logic b);
        tx_bit(b);
        if (b) ones++;
        else   ones = 0;
        if (ones == 6) begin
            tx_bit(1'b0);
            ones = 0;
        end
    endtask

    task automatic send(input int n, input bit dribble);
        tx_lvl = 1'b1;
        for (int i = 0; i < 7; i++) tx_bit(1'b0);
        tx_bit(1'b1);
        ones = 1;
        for (int i = 0; i < n; i++)
            for (int j = 0; j < 8; j++) tx_data(pkt[i][j]);
        if (dribble) tx_bit(1'b1);
        put(1'b0, 1'b0, 2 * OS);
        put(1'b0, 1'b1, 5 * OS);
    endtask

    task automatic clear_mon();
        got_q.delete();
        done_n = 0;
        ovf_n = 0;
        last_cnt = -1;
    endtask

    task automatic expect_pkt(input int n, input string tag);
        check({tag, " byte count seen"}, got_q.size(), n);
        for (int i = 0; i < n && i < got_q.size(); i++)
            check({tag, " R7 byte value"}, int'(got_q[i]), int'(pkt[i]));
        check("R9 done pulses", done_n, 1);
        check("R9 reported byte count", last_cnt, n);
        check("R10 no overflow", ovf_n, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R1 byte_valid in reset", int'(byte_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 byte_valid after reset", int'(byte_valid), 0);
        check("R1 pkt_done after reset", int'(pkt_done), 0);
        check("R1 overflow after reset", int'(overflow), 0);
        put(1'b0, 1'b1, 4 * OS);

        // R5 R7 R9: every byte value, nominal bit width
        for (int k = 0; k < 64; k++) begin
            for (int i = 0; i < 4; i++) pkt[i] = 8'(4 * k + i);
            clear_mon();
            send(4, 1'b0);
            expect_pkt(4, "R5 sweep");
        end

        // R6: all-ones payloads of every length
        for (int n = 1; n <= BUF; n++) begin
            for (int i = 0; i < n; i++) pkt[i] = 8'hFF;
            clear_mon();
            send(n, 1'b0);
            expect_pkt(n, "R6 stuffing");
        end
        pkt[0] = 8'h7E; pkt[1] = 8'hFC; pkt[2] = 8'h3F; pkt[3] = 8'hF8;
        clear_mon();
        send(4, 1'b0);
        expect_pkt(4, "R6 stuff mix");

        // R4: bit widths alternate 7 and 9 clocks
        jitter = 1'b1;
        for (int k = 0; k < 64; k++) begin
            for (int i = 0; i < 4; i++) pkt[i] = 8'(4 * k + i) ^ 8'hA5;
            clear_mon();
            send(4, 1'b0);
            expect_pkt(4, "R4 jitter");
        end
        jitter = 1'b0;

        // R9: empty packet
        clear_mon();
        send(0, 1'b0);
        expect_pkt(0, "R9 empty");

        // R8: one dribble bit before end of packet
        pkt[0] = 8'hC3; pkt[1] = 8'h11;
        clear_mon();
        send(2, 1'b1);
        expect_pkt(2, "R8 dribble");

        // R2: K bits while bus was in SE0 are ignored
        clear_mon();
        put(1'b0, 1'b0, 4 * OS);
        put(1'b1, 1'b0, 2 * OS);
        put(1'b0, 1'b0, 2 * OS);
        put(1'b0, 1'b1, 5 * OS);
        pkt[0] = 8'h5A; pkt[1] = 8'h99;
        send(2, 1'b0);
        expect_pkt(2, "R2 idle wait");

        // R3: lone K then J does not lock
        clear_mon();
        put(1'b1, 1'b0, OS);
        put(1'b0, 1'b1, 3 * OS);
        pkt[0] = 8'h2D;
        send(1, 1'b0);
        expect_pkt(1, "R3 false start");

        // R10: one byte too many
        for (int i = 0; i < 5; i++) pkt[i] = 8'(i + 1);
        clear_mon();
        send(5, 1'b0);
        check("R10 bytes before overflow", got_q.size(), BUF);
        for (int i = 0; i < BUF && i < got_q.size(); i++)
            check("R10 byte value", int'(got_q[i]), int'(pkt[i]));
        check("R10 overflow pulses", ovf_n, 1);
        check("R10 no done after overflow", done_n, 0);
        pkt[0] = 8'hE1;
        clear_mon();
        send(1, 1'b0);
        expect_pkt(1, "R10 recovery");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule